// File: doc/BRIEF.md
# Multi-channel bit capture packetizer

This block watches several single-bit signal lines and samples all of them on the same clock edge whenever a shared sampling strobe is high. Each line is treated as its own channel. Its bits are gathered into bytes with the first sample in the most significant bit. The bytes fill one of two payload buffers that belong to that channel. When a buffer is full, or when it has held data for too long, it is closed and queued for output. Capture then moves straight on to the channel's other buffer, so no sample is lost at the switch.

A closed buffer leaves the block as one packet on a byte-wide valid/ready stream. Each packet starts with an 8-byte header that names the channel, the buffer, a per-channel sequence number and the payload length. A full payload is 504 bytes, so a full packet is exactly 512 bytes. Only one packet is on the stream at a time, and channels that have packets waiting are served in round-robin order. If a buffer closes while the channel's other buffer is still waiting to be sent, its data is dropped. An overflow pulse is raised for that channel, and the sequence number still advances, so the receiver can see the gap.

Top module: `bitcap_packetizer`

## Requirements
- R1: When `sample_en` is high at a clock edge, every line is sampled at that edge into its own channel. Eight samples make one payload byte, and the first of the eight goes into bit 7.
- R2: A buffer that reaches `PAYLOAD` bytes (504 by default) is closed at the edge that stores its last byte. It gives a packet of exactly `PAYLOAD` + 8 bytes.
- R3: The header is 8 bytes: byte 0 is the channel index, byte 1 is the buffer index (0 or 1), bytes 2 to 5 are the 32-bit sequence number with the low byte first, and bytes 6 to 7 are the payload byte count with the low byte first. The payload follows in capture order.
- R4: Each channel's sequence number starts at 0 after reset. It goes up by one every time a buffer of that channel closes, whether the buffer is sent or dropped.
- R5: A non-empty buffer that has not filled is closed at the `TIMEOUT`-th clock edge, counting the edge that stored its first byte as the first. Its packet carries only the bytes stored so far, and bits not yet forming a byte stay in capture.
- R6: After a buffer closes, the next completed byte of that channel goes into the first slot of the channel's other buffer, with no sample dropped or repeated.
- R7: If a buffer closes while the channel's other buffer still waits to be sent, that channel's `overflow` bit is high for exactly the one cycle after the closing edge. The closed data is discarded and capture restarts empty in the same buffer.
- R8: `out_valid` and `out_data` hold steady while `out_ready` is low. `out_last` marks the final byte of each packet, and bytes of two packets never mix.
- R9: When the stream is idle and packets are waiting, the next packet comes from the first waiting channel after the one served last, in rising index order with wrap-around. Channel 0 is searched first after reset.
- R10: While reset is asserted, `out_valid` and all `overflow` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Sample all lines at this edge |
| lines | input | NCH | One signal line per channel |
| out_data | output | 8 | Packet byte |
| out_valid | output | 1 | `out_data` holds a valid byte |
| out_last | output | 1 | Final byte of the current packet |
| out_ready | input | 1 | Receiver accepts the byte this cycle |
| overflow | output | NCH | One-cycle pulse: a closed buffer was dropped |

## Verification
The bench holds the receiver stalled while every channel samples at full rate, so buffers fill behind a pending one. A design that overwrote the pending buffer, lost the pulse, or did not advance the sequence number on a drop would show wrong payload bytes or a header with a missing gap. Sparse sampling makes timeout flushes happen, each with its own partial length, and a timer that counts from the wrong edge shifts every byte boundary between packets. A round-robin check at each packet start catches an arbiter that favours a fixed channel, and the stall checks catch an output that changes or splits a packet while `out_ready` is low.

// File: rtl/bitcap_packetizer.sv
module bitcap_packetizer #(
  parameter int NCH     = 2,
  parameter int PAYLOAD = 504,
  parameter int TIMEOUT = 100000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_en,
  input  logic [NCH-1:0] lines,
  output logic [7:0]     out_data,
  output logic           out_valid,
  output logic           out_last,
  input  logic           out_ready,
  output logic [NCH-1:0] overflow
);
  localparam int HDR   = 8;
  localparam int PKT   = HDR + PAYLOAD;
  localparam int PW    = $clog2(PAYLOAD + 1);
  localparam int IW    = $clog2(PKT);
  localparam int TW    = $clog2(TIMEOUT + 1);
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int DEPTH = NCH * 2 * PAYLOAD;
  localparam int AW    = $clog2(DEPTH);

  logic [6:0]    sh   [NCH];
  logic [2:0]    bc   [NCH];
  logic [PW-1:0] wptr [NCH];
  logic [PW-1:0] plen [NCH];
  logic [PW-1:0] cnext[NCH];
  logic [TW-1:0] tcnt [NCH];
  logic [31:0]   seq  [NCH];
  logic [31:0]   pseq [NCH];
  logic [NCH-1:0] cur, pend, bdone, hand;
  logic [7:0]    mem  [DEPTH];

  logic          busy;
  logic [CW-1:0] sel, rr, pick;
  logic [IW-1:0] idx;
  logic          anyp;
  logic [15:0]   len16;
  logic [AW-1:0] raddr;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      bdone[c] = sample_en && (bc[c] == 3'd7);
      cnext[c] = wptr[c] + PW'(bdone[c]);
      hand[c]  = (cnext[c] == PW'(PAYLOAD)) ||
                 ((tcnt[c] == TW'(TIMEOUT - 1)) && (cnext[c] != '0));
    end
  end

  always_comb begin
    anyp = 1'b0;
    pick = '0;
    for (int k = 1; k <= NCH; k++) begin
      if (!anyp && pend[(int'(rr) + k) % NCH]) begin
        anyp = 1'b1;
        pick = CW'((int'(rr) + k) % NCH);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++)
      if (bdone[c])
        mem[AW'((c * 2 + int'(cur[c])) * PAYLOAD + int'(wptr[c]))] <= {sh[c], lines[c]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sh[c] <= '0; bc[c] <= '0; wptr[c] <= '0; plen[c] <= '0;
        tcnt[c] <= '0; seq[c] <= '0; pseq[c] <= '0;
      end
      cur <= '0; pend <= '0; overflow <= '0;
      busy <= 1'b0; sel <= '0; idx <= '0; rr <= CW'(NCH - 1);
    end else begin
      for (int c = 0; c < NCH; c++) begin
        overflow[c] <= 1'b0;
        if (sample_en) begin
          sh[c] <= {sh[c][5:0], lines[c]};
          bc[c] <= bc[c] + 3'd1;
        end
        if (hand[c]) begin
          wptr[c] <= '0;
          tcnt[c] <= '0;
          seq[c]  <= seq[c] + 32'd1;
          if (pend[c]) begin
            overflow[c] <= 1'b1;
          end else begin
            pend[c] <= 1'b1;
            plen[c] <= cnext[c];
            pseq[c] <= seq[c];
            cur[c]  <= ~cur[c];
          end
        end else begin
          wptr[c] <= cnext[c];
          tcnt[c] <= (cnext[c] == '0) ? '0 : tcnt[c] + TW'(1);
        end
        if (busy && out_ready && out_last && (int'(sel) == c))
          pend[c] <= 1'b0;
      end
      if (!busy) begin
        if (anyp) begin
          busy <= 1'b1;
          sel  <= pick;
          rr   <= pick;
          idx  <= '0;
        end
      end else if (out_ready) begin
        idx <= idx + IW'(1);
        if (out_last) busy <= 1'b0;
      end
    end
  end

  assign out_valid = busy;
  assign len16     = 16'(plen[sel]);
  assign raddr     = AW'((int'(sel) * 2 + int'(!cur[sel])) * PAYLOAD + int'(idx) - HDR);
  assign out_last  = busy && (int'(idx) == HDR + int'(plen[sel]) - 1);

  always_comb begin
    case (int'(idx))
      0:       out_data = 8'(sel);
      1:       out_data = {7'd0, !cur[sel]};
      2:       out_data = pseq[sel][7:0];
      3:       out_data = pseq[sel][15:8];
      4:       out_data = pseq[sel][23:16];
      5:       out_data = pseq[sel][31:24];
      6:       out_data = len16[7:0];
      7:       out_data = len16[15:8];
      default: out_data = mem[raddr];
    endcase
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R8
  AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready && out_last)); // R8
  AST_SEND_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend[sel] && (plen[sel] != '0)); // R5

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      overflow[g] |=> !overflow[g]); // R7
    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wptr[g] < PW'(PAYLOAD)); // R2
  end
endmodule

// File: tb/test_bitcap_packetizer.sv
`timescale 1ns/1ps
module test_bitcap_packetizer;
  localparam int NCH = 3, PAYLOAD = 504, TMO = 5000, HDR = 8;

  logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, out_ready = 1'b0;
  logic [NCH-1:0] lines = '0;
  logic [7:0] out_data;
  logic out_valid, out_last;
  logic [NCH-1:0] overflow;

  always #2.5 clk = ~clk;

  bitcap_packetizer #(.NCH(NCH), .PAYLOAD(PAYLOAD), .TIMEOUT(TMO)) i_bitcap_packetizer (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .lines(lines),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready), .overflow(overflow));

  int checks = 0, fails = 0, edge_no = 0, n_ovf = 0, last_served = NCH - 1;
  int se_pct = 0, rdy_pct = 0;
  bit saw_full = 0, saw_part = 0, done = 0;

  int          m_bits [NCH];
  logic [7:0]  m_sh   [NCH];
  logic [7:0]  m_buf  [NCH][$];
  logic [7:0]  m_exp  [NCH][$];
  int          m_first[NCH];
  bit          m_cur  [NCH];
  bit          m_pend [NCH];
  int unsigned m_seq  [NCH];
  logic [NCH-1:0] m_ovf;
  logic [7:0]  rx[$];

  logic s_rst = 0, s_se = 0, s_valid = 0, s_ready = 0, s_last = 0;
  logic [NCH-1:0] s_ln = '0;
  logic [7:0] s_data = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_packet();
    int ch, len, bad_i;
    logic [7:0] e, bad_a, bad_e;
    bit ok;
    ch  = int'(rx[0]);
    len = int'(rx[6]) | (int'(rx[7]) << 8);
    chk(ch < NCH, "R3", "channel byte", ch, 0);
    if (ch >= NCH) begin rx.delete(); return; end
    chk(rx.size() == HDR + len, "R3", "packet size vs length field", rx.size(), HDR + len);
    if (len == PAYLOAD) saw_full = 1; else saw_part = 1;
    ok = 1; bad_i = 0; bad_a = 0; bad_e = 0;
    foreach (rx[i]) begin
      if (m_exp[ch].size() == 0) begin
        if (ok) begin ok = 0; bad_i = i; bad_a = rx[i]; bad_e = 0; end
      end else begin
        e = m_exp[ch].pop_front();
        if (ok && e !== rx[i]) begin ok = 0; bad_i = i; bad_a = rx[i]; bad_e = e; end
      end
    end
    if (!ok) $display("  packet of channel %0d differs at byte %0d", ch, bad_i);
    chk(ok, "R1 R3 R4 R6", "packet byte", bad_a, bad_e);
    m_pend[ch] = 0;
    rx.delete();
  endtask

  task automatic model_edge();
    int n;
    for (int c = 0; c < NCH; c++) begin
      m_ovf[c] = 1'b0;
      if (s_se) begin
        m_sh[c] = {m_sh[c][6:0], s_ln[c]};
        m_bits[c]++;
        if (m_bits[c] == 8) begin
          m_bits[c] = 0;
          m_buf[c].push_back(m_sh[c]);
          if (m_buf[c].size() == 1) m_first[c] = edge_no;
        end
      end
      n = m_buf[c].size();
      if (n == PAYLOAD || (n > 0 && edge_no - m_first[c] == TMO - 1)) begin
        if (m_pend[c]) begin
          m_ovf[c] = 1'b1;
          n_ovf++;
        end else begin
          m_exp[c].push_back(8'(c));
          m_exp[c].push_back(8'(m_cur[c]));
          for (int b = 0; b < 4; b++) m_exp[c].push_back(8'(m_seq[c] >> (8 * b)));
          m_exp[c].push_back(8'(n));
          m_exp[c].push_back(8'(n >> 8));
          foreach (m_buf[c][i]) m_exp[c].push_back(m_buf[c][i]);
          m_pend[c] = 1;
          m_cur[c]  = !m_cur[c];
        end
        m_seq[c]++;
        m_buf[c].delete();
      end
    end
    if (s_valid && s_ready) begin
      rx.push_back(s_data);
      if (s_last) check_packet();
    end
  endtask

  task automatic step();
    int exp_ch;
    if (s_rst) begin
      edge_no++;
      if (!s_valid && out_valid) begin
        exp_ch = -1;
        for (int k = 1; k <= NCH; k++)
          if (exp_ch < 0 && m_pend[(last_served + k) % NCH]) exp_ch = (last_served + k) % NCH;
        chk(int'(out_data) == exp_ch, "R9", "round-robin channel", out_data, exp_ch);
        last_served = int'(out_data);
      end
      if (s_valid && !s_ready)
        chk(out_valid && out_data == s_data && out_last == s_last, "R8", "held byte under stall",
            out_data, s_data);
      model_edge();
      chk(overflow == m_ovf, "R7", "overflow pulse", overflow, m_ovf);
    end
    sample_en = rst_n && ($urandom_range(99) < se_pct);
    lines     = NCH'($urandom);
    out_ready = ($urandom_range(99) < rdy_pct);
    s_rst = rst_n; s_se = sample_en; s_ln = lines;
    s_valid = out_valid; s_ready = out_ready; s_data = out_data; s_last = out_last;
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      step();
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_bits[c] = 0; m_sh[c] = 0; m_first[c] = 0; m_cur[c] = 0; m_pend[c] = 0; m_seq[c] = 0;
    end
    m_ovf = '0;
    run(4);
    chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    chk(overflow == '0, "R10", "overflow in reset", overflow, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    se_pct = 100; rdy_pct = 100; run(12000);
    se_pct = 12;  rdy_pct = 50;  run(15000);
    se_pct = 100; rdy_pct = 0;   run(16000);
    rdy_pct = 70;                run(8000);
    se_pct = 0;   rdy_pct = 100; run(8000);
    for (int c = 0; c < NCH; c++) begin
      chk(m_exp[c].size() == 0, "R2", "undelivered expected bytes", m_exp[c].size(), 0);
      chk(!m_pend[c], "R8", "buffer still pending", m_pend[c], 0);
    end
    chk(rx.size() == 0 && !out_valid, "R8", "stream idle at end", rx.size(), 0);
    chk(saw_full, "R2", "full packet seen", saw_full, 1);
    chk(saw_part, "R5", "timeout packet seen", saw_part, 1);
    chk(n_ovf > 0, "R7", "overflow events", n_ovf, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule